// File: doc/BRIEF.md
# Compare-Match Periodic Tick Timer

This block is a memory-mapped timer that produces a periodic interrupt for a processor board. A free-running 32-bit up-counter advances once on each pulse of a 1 MHz timebase enable input. When the counter reaches the value in a 32-bit compare register, three things happen on the same clock edge:

- a 4-bit event counter steps;
- an interrupt pending flag is set;
- if the clear-on-compare mode is selected, the counter restarts from zero.

With clear-on-compare set, one period spans the compare value plus one timebase ticks. Software reads the event count and the counter together. It can read the count, read the counter, and read the count again. If the count changed, it reads the counter once more. This gives a consistent elapsed time even when interrupts were missed.

Software reaches the registers over a simple 32-bit word bus with byte enables. The byte at the lowest offset of a word sits on bits 31:24. The interrupt side drives a request, which is the pending flag gated by an enable, together with a 3-bit priority level. All logic runs on one system clock, and the timebase is a single-cycle enable pulse in that clock domain.

Top module: `pcc_tick_timer`

## Requirements
- R1: After reset the counter, the compare value, every control bit, the event count and the pending flag are 0, and `irq_req` is 0.
- R2: The counter steps by one on each clock where `tick_1us` is high and the run bit (bit 0 of the control byte) is 1. In every other case it holds its value.
- R3: A match occurs on a clock where `tick_1us` is high, the run bit is 1, and the counter equals the compare value. On a match the counter becomes 0 if clear-on-compare (control bit 1) is 1. Otherwise it becomes compare+1, wrapping modulo 2^32.
- R4: The event count is read in control byte bits 7:4. It increments on every match, on the same edge that updates the counter, and wraps from 15 to 0.
- R5: Writing 1 to control bit 2 zeroes the event count. Control bits 3:2 always read as 0. If a match happens in the same cycle as the clear, the count becomes 1.
- R6: A match sets the pending flag whether or not the interrupt is enabled. The pending flag reads in bit 5 of the interrupt byte.
- R7: `irq_req` is high exactly when the pending flag and the interrupt enable (interrupt byte bit 4) are both 1. `irq_lvl` shows interrupt byte bits 2:0.
- R8: Writing 1 to interrupt byte bit 3 clears the pending flag. If a match happens in the same cycle as the clear, the flag stays set. Bit 3 always reads as 0, and bits 7:6 always read as 0.
- R9: A write to the counter loads the written bytes on the next edge, lane by lane under the byte enables. The write takes priority over a timebase step in the same cycle.
- R10: Register map by word address `bus_addr[4:2]`:
  - 1 (offset 0x04) is the compare register.
  - 2 (offset 0x08) is the counter.
  - 5 (offset 0x14) holds the control byte at offset 0x17, on bits 7:0 under `bus_be[0]`.
  - 6 (offset 0x18) holds the interrupt byte at offset 0x1b, on bits 7:0 under `bus_be[0]`.
  - `bus_be[3]` selects bits 31:24, the lowest byte offset.
  - Other word addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1us | input | 1 | Single-cycle timebase enable, nominally 1 MHz |
| bus_addr | input | 3 | Word address, byte offset bits 4:2 |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_be | input | 4 | Byte enables; bit 3 selects bits 31:24 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_req | output | 1 | Interrupt request |
| irq_lvl | output | 3 | Interrupt priority level |

## Verification
The assertions assume that `tick_1us` and the bus strobes are sampled as ordinary synchronous inputs, and that a write to the counter may fall in the same cycle as a timebase pulse. For that reason, the counter-stepping properties exclude cycles in which the counter is written. The stimulus changes every input on the falling clock edge and holds each strobe for exactly one cycle. It deliberately lines up clear strobes with matching timebase pulses, so that the same-cycle priority rules are exercised rather than assumed.

// File: rtl/pcc_tick_timer.sv
module pcc_tick_timer #(
  parameter int CNT_W = 32,
  parameter int EVT_W = 4,
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_1us,
  input  logic [4:2]       bus_addr,
  input  logic             bus_wr,
  input  logic [3:0]       bus_be,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             irq_req,
  output logic [LVL_W-1:0] irq_lvl
);

  localparam logic [2:0] W_CMP = 3'd1;
  localparam logic [2:0] W_CNT = 3'd2;
  localparam logic [2:0] W_CTL = 3'd5;
  localparam logic [2:0] W_IRQ = 3'd6;

  logic [CNT_W-1:0] cnt, cmp;
  logic [EVT_W-1:0] evt;
  logic [LVL_W-1:0] lvl;
  logic run, coc, ien, pend;

  function automatic logic [CNT_W-1:0] merge(input logic [CNT_W-1:0] old,
                                              input logic [31:0] nw,
                                              input logic [3:0] be);
    logic [CNT_W-1:0] r;
    r = old;
    for (int i = 0; i < 4; i++)
      if (be[i]) r[8*i +: 8] = nw[8*i +: 8];
    return r;
  endfunction

  wire cmp_wr   = bus_wr && bus_addr == W_CMP;
  wire cnt_wr   = bus_wr && bus_addr == W_CNT;
  wire ctl_wr   = bus_wr && bus_addr == W_CTL && bus_be[0];
  wire irq_wr   = bus_wr && bus_addr == W_IRQ && bus_be[0];
  wire step     = tick_1us && run;
  wire match    = step && cnt == cmp;
  wire evt_clr  = ctl_wr && bus_wdata[2];
  wire pend_clr = irq_wr && bus_wdata[3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      cmp  <= '0;
      evt  <= '0;
      lvl  <= '0;
      run  <= 1'b0;
      coc  <= 1'b0;
      ien  <= 1'b0;
      pend <= 1'b0;
    end else begin
      if (cnt_wr)
        cnt <= merge(cnt, bus_wdata, bus_be);
      else if (step)
        cnt <= (match && coc) ? '0 : cnt + 1'b1;

      if (cmp_wr)
        cmp <= merge(cmp, bus_wdata, bus_be);

      if (ctl_wr) begin
        run <= bus_wdata[0];
        coc <= bus_wdata[1];
      end

      if (evt_clr)
        evt <= match ? EVT_W'(1) : '0;
      else if (match)
        evt <= evt + 1'b1;

      if (irq_wr) begin
        ien <= bus_wdata[4];
        lvl <= bus_wdata[LVL_W-1:0];
      end

      if (match)
        pend <= 1'b1;
      else if (pend_clr)
        pend <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      W_CMP: bus_rdata = 32'(cmp);
      W_CNT: bus_rdata = 32'(cnt);
      W_CTL: bus_rdata = {24'b0, evt, 2'b00, coc, run};
      W_IRQ: bus_rdata = {24'b0, 2'b00, pend, ien, 1'b0, lvl};
      default: bus_rdata = '0;
    endcase
  end

  assign irq_req = pend & ien;
  assign irq_lvl = lvl;

  // R2
  step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !match && !cnt_wr) |=> cnt == $past(cnt) + 1'b1);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !cnt_wr) |=> $stable(cnt));

  // R3
  coc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match && coc && !cnt_wr) |=> cnt == '0);

  // R4
  evt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !evt_clr) |=> evt == $past(evt) + 1'b1);

  // R6
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> pend);

  // R8
  pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_clr && !match) |=> !pend && !irq_req);

  // R1
  rst_chk: assert property (@(posedge clk)
    !rst_n |=> (cnt == '0 && evt == '0 && !irq_req && !run));

endmodule

// File: tb/tb_pcc_tick_timer.sv
module tb_pcc_tick_timer;
  logic clk = 0, rst_n = 0, tick_1us = 0, bus_wr = 0;
  logic [4:2] bus_addr = '0;
  logic [3:0] bus_be = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq_req;
  logic [2:0] irq_lvl;
  int checks = 0, fails = 0;
  bit done = 0;

  localparam logic [2:0] A_CMP = 3'd1, A_CNT = 3'd2, A_CTL = 3'd5, A_IRQ = 3'd6;

  pcc_tick_timer dut (.clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .irq_lvl(irq_lvl));

  always #2.5 clk = ~clk;

  // {cmp16, coc1, ticks8, exp_cnt16, exp_evt4, exp_pend1, pad2}
  localparam int NV = 7;
  localparam logic [47:0] VEC [NV] = '{
    {16'd5, 1'b1, 8'd3,  16'd3, 4'd0, 1'b0, 2'b0},
    {16'd5, 1'b1, 8'd6,  16'd0, 4'd1, 1'b1, 2'b0},
    {16'd5, 1'b1, 8'd14, 16'd2, 4'd2, 1'b1, 2'b0},
    {16'd5, 1'b0, 8'd7,  16'd7, 4'd1, 1'b1, 2'b0},
    {16'd0, 1'b1, 8'd4,  16'd0, 4'd4, 1'b1, 2'b0},
    {16'd2, 1'b1, 8'd48, 16'd0, 4'd0, 1'b1, 2'b0},
    {16'd1, 1'b1, 8'd35, 16'd1, 4'd1, 1'b1, 2'b0}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bwrite(logic [2:0] a, logic [31:0] d, logic [3:0] be, logic tk = 1'b0);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1; tick_1us = tk;
    @(negedge clk);
    bus_wr = 0; bus_be = '0; tick_1us = 0;
  endtask

  task automatic bread(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_1us = 1;
      @(negedge clk) tick_1us = 0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    do_reset();
    // R1 reset state
    bread(A_CNT, rd); check("R1 cnt", rd, 0);
    bread(A_CMP, rd); check("R1 cmp", rd, 0);
    bread(A_CTL, rd); check("R1 ctl", rd, 0);
    bread(A_IRQ, rd); check("R1 irq", rd, 0);
    check("R1 irq_req", 32'(irq_req), 0);

    // R2 no counting while run bit clear
    pulse(5);
    bread(A_CNT, rd); check("R2 hold", rd, 0);

    for (int v = 0; v < NV; v++) begin
      do_reset();
      bwrite(A_CMP, 32'(VEC[v][47:32]), 4'hF);
      bwrite(A_CTL, {30'b0, VEC[v][31], 1'b1}, 4'h1);
      pulse(int'(VEC[v][30:23]));
      bread(A_CNT, rd); check("R2 R3 table cnt", rd, 32'(VEC[v][22:7]));
      bread(A_CTL, rd); check("R4 table evt", 32'(rd[7:4]), 32'(VEC[v][6:3]));
      bread(A_IRQ, rd); check("R6 table pend", 32'(rd[5]), 32'(VEC[v][2]));
      check("R7 no req without enable", 32'(irq_req), 0);
    end

    // R9 and R10 counter load, byte lanes, address map
    do_reset();
    bwrite(A_CNT, 32'h12345678, 4'hF);
    bread(A_CNT, rd); check("R9 full load", rd, 32'h12345678);
    bwrite(A_CNT, 32'h000000AB, 4'h1);
    bread(A_CNT, rd); check("R9 lane load", rd, 32'h123456AB);
    bwrite(A_CMP, 32'hAA000000, 4'h8);
    bread(A_CMP, rd); check("R10 top lane", rd, 32'hAA000000);
    bwrite(3'd0, 32'hFFFFFFFF, 4'hF);
    bread(3'd0, rd); check("R10 unmapped", rd, 0);
    bwrite(A_CTL, 32'h1, 4'h1);
    bwrite(A_CNT, 32'h00000010, 4'hF, 1'b1);
    bread(A_CNT, rd); check("R9 write beats tick", rd, 32'h10);

    // R3 without clear-on-compare, wrap at 2^32
    bwrite(A_CTL, 32'h0, 4'h1);
    bwrite(A_CNT, 32'hFFFFFFFE, 4'hF);
    bwrite(A_CMP, 32'hFFFFFFFF, 4'hF);
    bwrite(A_CTL, 32'h5, 4'h1);
    pulse(1);
    bread(A_CNT, rd); check("R3 pre", rd, 32'hFFFFFFFF);
    pulse(1);
    bread(A_CNT, rd); check("R3 wrap", rd, 0);
    bread(A_CTL, rd); check("R4 R5 ctl read", rd, 32'h11);

    // R5 clear coincident with match
    do_reset();
    bwrite(A_CMP, 32'd3, 4'hF);
    bwrite(A_CTL, 32'h3, 4'h1);
    pulse(7);
    bread(A_CTL, rd); check("R4 evt before clear", 32'(rd[7:4]), 1);
    bwrite(A_CTL, 32'h7, 4'h1, 1'b1);
    bread(A_CTL, rd); check("R5 match wins", rd, 32'h13);
    bwrite(A_CTL, 32'h7, 4'h1);
    bread(A_CTL, rd); check("R5 plain clear", rd, 32'h03);

    // R7 enable gating and level
    bwrite(A_IRQ, 32'h06, 4'h1);
    check("R7 disabled", 32'(irq_req), 0);
    bwrite(A_IRQ, 32'h16, 4'h1);
    check("R7 enabled", 32'(irq_req), 1);
    check("R7 level", 32'(irq_lvl), 6);

    // R8 clear versus match
    pulse(3);
    bwrite(A_IRQ, 32'h1E, 4'h1, 1'b1);
    check("R8 match wins", 32'(irq_req), 1);
    bwrite(A_IRQ, 32'h1E, 4'h1);
    check("R8 cleared", 32'(irq_req), 0);
    bread(A_IRQ, rd); check("R8 readback", rd, 32'h16);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule